// File: doc/BRIEF.md
# Serial Audio Frame Transmitter

The block serializes parallel audio samples onto a single data pin, framed by an externally supplied bit clock and frame-sync signal. Both of these are sampled by the block's own system clock, which must run several times faster than the bit clock. A frame may carry one phase or two. Each phase has its own word count and its own word length, chosen from 8, 12, 16, 20, 24 or 32 bits. The first bit of a frame follows the detected frame start either at once or one bit clock later.

Samples arrive from an upstream FIFO through a valid/ready pair. Exactly one word is requested at the start of every word slot. If no word is available at that moment, the slot is filled with zeros and a sticky underrun flag is raised. Common stereo layouts map onto the configuration as follows:
- Two-phase frames with one word per phase and a one-bit delay give the classic stereo I2S layout.
- The same frame shape with no delay gives left-justified data.
- A single phase holding all channels gives the DSP-style short-pulse layouts.

Top module: `audio_frame_tx`

## Requirements
- R1: The word-length code of each phase selects the word width: 0 gives 8 bits, 1 gives 12, 2 gives 16, 3 gives 20, 4 gives 24 and 5 gives 32. Codes 6 and 7 also give 32 bits. A word of width N is taken from bits N-1..0 of `s_data`.
- R2: Words leave most significant bit first. `sdata` changes only in the system cycle that follows a detected falling edge of `bclk`, and it is meant to be sampled on the rising edge.
- R3: A frame starts at a rising edge of `bclk` at which frame sync is sampled active after having been sampled inactive at the previous rising edge. Frame sync is active high when `cfg_fs_low` is 0 and active low when it is 1. Holding frame sync active does not start another frame.
- R4: With `cfg_delay` = 0, the first data bit is the one sampled at the first rising edge after the frame start. With `cfg_delay` = 1, it is the one sampled at the second rising edge after the start, and the bit before it is zero.
- R5: Phase one carries `cfg_len1`+1 words of the width set by `cfg_wcode1`. When `cfg_dual` is 1, it is followed without a gap by `cfg_len2`+1 words of the width set by `cfg_wcode2`.
- R6: After the last bit of a frame, `sdata` is zero until the next frame's data begins. No word is requested from the FIFO after the last slot.
- R7: If `s_valid` is low when a word slot begins, that slot is sent as zeros and `underrun` is set. `underrun` then stays set until reset.
- R8: A frame start that arrives while a frame is still being sent abandons the rest of that frame. The new frame then begins from its first word in phase one.
- R9: `s_ready` is high for exactly one system cycle at the start of each word slot. A word is consumed only when `s_valid` and `s_ready` are both high.
- R10: While reset is held and right after it, `sdata`, `underrun` and `s_ready` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bit clock and frame sync |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Serial bit clock, synchronous to clk |
| fsync | input | 1 | Frame-sync input, polarity set by cfg_fs_low |
| cfg_fs_low | input | 1 | 1: frame sync is active low |
| cfg_delay | input | 1 | Data delay after frame start, in bit clocks (0 or 1) |
| cfg_dual | input | 1 | 1: the frame has a second phase |
| cfg_len1 | input | LEN_W | Words in phase one, minus one |
| cfg_len2 | input | LEN_W | Words in phase two, minus one |
| cfg_wcode1 | input | 3 | Word-length code of phase one |
| cfg_wcode2 | input | 3 | Word-length code of phase two |
| s_valid | input | 1 | A sample word is offered |
| s_data | input | 32 | Sample word, right-aligned |
| s_ready | output | 1 | Word accepted at this slot start |
| sdata | output | 1 | Serial data output |
| underrun | output | 1 | Sticky flag: a slot found no word |

## Verification
The bench looks for the following corner cases and the symptom each bug would cause:
- The one-bit delay. A design that ignores it sends every frame one bit early.
- The move from phase one to phase two with a different word width. A design that keeps the old width truncates or pads the second phase.
- An I2S frame sync held active for half a frame. A level-triggered design restarts the frame on every bit.
- A frame sync arriving in the middle of a frame. A design without abort keeps shifting the stale word.
- A spare word left in the FIFO after a frame. A design that requests one slot too many drains it.
- A FIFO that runs dry. A design that stalls, or repeats the last word, shows up against the expected zero slots, and so does a design whose underrun flag is not sticky.

// File: rtl/aft_pkg.sv
package aft_pkg;

  localparam int unsigned AFT_DW    = 32;
  localparam int unsigned AFT_CNT_W = 6;

  typedef logic [2:0]           wcode_t;
  typedef logic [AFT_CNT_W-1:0] bitcnt_t;

  // Word width in bits for a word-length code; unused codes act as 32.
  function automatic bitcnt_t wcode_bits(input wcode_t code);
    case (code)
      3'd0:    return bitcnt_t'(8);
      3'd1:    return bitcnt_t'(12);
      3'd2:    return bitcnt_t'(16);
      3'd3:    return bitcnt_t'(20);
      3'd4:    return bitcnt_t'(24);
      default: return bitcnt_t'(32);
    endcase
  endfunction

  // Moves the low n bits of a word up to the top of the shift register.
  function automatic logic [AFT_DW-1:0] align_msb(input logic [AFT_DW-1:0] w,
                                                   input bitcnt_t n);
    return w << (bitcnt_t'(AFT_DW) - n);
  endfunction

endpackage

// File: rtl/aft_edge.sv
module aft_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic fsync,
  input  logic fs_low,
  output logic bit_rise,
  output logic bit_fall,
  output logic frame_start
);

  logic bclk_q;
  logic fs_seen;
  logic fs_act;

  assign fs_act      = fsync ^ fs_low;
  assign bit_rise    = bclk & ~bclk_q;
  assign bit_fall    = ~bclk & bclk_q;
  assign frame_start = bit_rise & fs_act & ~fs_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q  <= 1'b1;
      fs_seen <= 1'b0;
    end else begin
      bclk_q <= bclk;
      if (bit_rise) fs_seen <= fs_act;
    end
  end

endmodule

// File: rtl/aft_seq.sv
module aft_seq
  import aft_pkg::*;
#(
  parameter int unsigned LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_fall,
  input  logic             frame_start,
  input  logic             cfg_dual,
  input  logic             cfg_delay,
  input  logic [LEN_W-1:0] cfg_len1,
  input  logic [LEN_W-1:0] cfg_len2,
  input  wcode_t           cfg_wcode1,
  input  wcode_t           cfg_wcode2,
  output logic             slot_start,
  output logic             shift_en,
  output logic             frame_end,
  output logic             active,
  output bitcnt_t          slot_bits
);

  localparam logic [LEN_W-1:0] WORD_ONE = {{(LEN_W-1){1'b0}}, 1'b1};

  logic             pend_q;
  logic             dly_q;
  logic             active_q;
  logic             phase_q;
  logic [LEN_W-1:0] word_q;
  bitcnt_t          bit_q;

  logic [LEN_W-1:0] cur_len;
  logic             word_done;
  logic             last_word;
  logic             to_phase2;
  logic             begin_frame;
  logic             next_word;
  logic             next_phase;

  always_comb begin
    cur_len     = phase_q ? cfg_len2 : cfg_len1;
    word_done   = active_q && (bit_q == '0);
    last_word   = (word_q == cur_len);
    to_phase2   = last_word && !phase_q && cfg_dual;
    begin_frame = bit_fall && pend_q && !dly_q;
    next_word   = bit_fall && word_done && (!last_word || to_phase2);
    frame_end   = bit_fall && word_done && last_word && !to_phase2;
    slot_start  = begin_frame || next_word;
    shift_en    = bit_fall && active_q && (bit_q != '0);
    next_phase  = begin_frame ? 1'b0 : (to_phase2 ? 1'b1 : phase_q);
    slot_bits   = wcode_bits(next_phase ? cfg_wcode2 : cfg_wcode1);
  end

  assign active = active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      dly_q    <= 1'b0;
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      word_q   <= '0;
      bit_q    <= '0;
    end else if (frame_start) begin
      pend_q   <= 1'b1;
      dly_q    <= cfg_delay;
      active_q <= 1'b0;
    end else if (bit_fall) begin
      if (pend_q) begin
        if (dly_q) begin
          dly_q <= 1'b0;
        end else begin
          pend_q   <= 1'b0;
          active_q <= 1'b1;
          phase_q  <= 1'b0;
          word_q   <= '0;
          bit_q    <= slot_bits - bitcnt_t'(1);
        end
      end else if (shift_en) begin
        bit_q <= bit_q - bitcnt_t'(1);
      end else if (next_word) begin
        phase_q <= next_phase;
        word_q  <= to_phase2 ? '0 : word_q + WORD_ONE;
        bit_q   <= slot_bits - bitcnt_t'(1);
      end else if (frame_end) begin
        active_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/aft_shift.sv
module aft_shift
  import aft_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_fall,
  input  logic              load,
  input  logic              shift,
  input  logic [AFT_DW-1:0] word,
  input  bitcnt_t           nbits,
  output logic              sdata
);

  logic [AFT_DW-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (bit_fall) begin
      if (load)       sh_q <= align_msb(word, nbits);
      else if (shift) sh_q <= sh_q << 1;
      else            sh_q <= '0;
    end
  end

  assign sdata = sh_q[AFT_DW-1];

endmodule

// File: rtl/audio_frame_tx.sv
module audio_frame_tx
  import aft_pkg::*;
#(
  parameter int unsigned LEN_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              fsync,
  input  logic              cfg_fs_low,
  input  logic              cfg_delay,
  input  logic              cfg_dual,
  input  logic [LEN_W-1:0]  cfg_len1,
  input  logic [LEN_W-1:0]  cfg_len2,
  input  logic [2:0]        cfg_wcode1,
  input  logic [2:0]        cfg_wcode2,
  input  logic              s_valid,
  input  logic [AFT_DW-1:0] s_data,
  output logic              s_ready,
  output logic              sdata,
  output logic              underrun
);

  // Internal events, named so the bound checker can observe them.
  logic    bit_rise;
  logic    bit_fall;
  logic    frame_start;
  logic    slot_start;
  logic    shift_en;
  logic    frame_end;
  logic    active;
  bitcnt_t slot_bits;

  logic [AFT_DW-1:0] slot_word;
  logic              underrun_q;

  aft_edge u_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .bclk        (bclk),
    .fsync       (fsync),
    .fs_low      (cfg_fs_low),
    .bit_rise    (bit_rise),
    .bit_fall    (bit_fall),
    .frame_start (frame_start)
  );

  aft_seq #(.LEN_W(LEN_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_fall    (bit_fall),
    .frame_start (frame_start),
    .cfg_dual    (cfg_dual),
    .cfg_delay   (cfg_delay),
    .cfg_len1    (cfg_len1),
    .cfg_len2    (cfg_len2),
    .cfg_wcode1  (cfg_wcode1),
    .cfg_wcode2  (cfg_wcode2),
    .slot_start  (slot_start),
    .shift_en    (shift_en),
    .frame_end   (frame_end),
    .active      (active),
    .slot_bits   (slot_bits)
  );

  assign slot_word = s_valid ? s_data : '0;

  aft_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_fall (bit_fall),
    .load     (slot_start),
    .shift    (shift_en),
    .word     (slot_word),
    .nbits    (slot_bits),
    .sdata    (sdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                       underrun_q <= 1'b0;
    else if (slot_start && !s_valid)  underrun_q <= 1'b1;
  end

  assign s_ready  = slot_start;
  assign underrun = underrun_q;

endmodule

// File: rtl/aft_checker.sv
module aft_checker (
  input logic clk,
  input logic rst_n,
  input logic bit_rise,
  input logic bit_fall,
  input logic frame_start,
  input logic frame_end,
  input logic active,
  input logic s_valid,
  input logic s_ready,
  input logic sdata,
  input logic underrun
);

  p_one_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bit_rise, bit_fall}));

  p_hold_between_falls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_fall |=> $stable(sdata));

  p_start_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> bit_rise);

  p_tail_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !sdata);

  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !s_valid) |=> underrun);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !active);

  p_ready_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> bit_fall);

  p_ready_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> !s_ready);

endmodule

bind audio_frame_tx aft_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_rise    (bit_rise),
  .bit_fall    (bit_fall),
  .frame_start (frame_start),
  .frame_end   (frame_end),
  .active      (active),
  .s_valid     (s_valid),
  .s_ready     (s_ready),
  .sdata       (sdata),
  .underrun    (underrun)
);

// File: tb/tb_audio_frame_tx.sv
`timescale 1ns/1ps
module tb_audio_frame_tx;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bclk, fsync;
  logic        cfg_fs_low, cfg_delay, cfg_dual;
  logic [6:0]  cfg_len1, cfg_len2;
  logic [2:0]  cfg_wcode1, cfg_wcode2;
  logic        s_valid;
  logic [31:0] s_data;
  wire         s_ready, sdata, underrun;

  always #4 clk = ~clk;

  audio_frame_tx dut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
    .cfg_fs_low(cfg_fs_low), .cfg_delay(cfg_delay), .cfg_dual(cfg_dual),
    .cfg_len1(cfg_len1), .cfg_len2(cfg_len2),
    .cfg_wcode1(cfg_wcode1), .cfg_wcode2(cfg_wcode2),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .sdata(sdata), .underrun(underrun)
  );

  int          checks = 0;
  int          errors = 0;
  bit          done = 0;
  event        rise_ev;
  logic        exp_b[$];
  string       exp_t[$];
  logic [31:0] fifo_q[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, expv, $time);
    end
  endtask

  function automatic int width_of(input int code);
    int tbl[6];
    tbl = '{8, 12, 16, 20, 24, 32};
    return (code < 6) ? tbl[code] : 32;
  endfunction

  // Upstream FIFO model: pop on handshake, present head between edges.
  always @(posedge clk)
    if (s_valid && s_ready && fifo_q.size() > 0) void'(fifo_q.pop_front());

  always @(negedge clk) begin
    s_valid = (fifo_q.size() > 0);
    s_data  = (fifo_q.size() > 0) ? fifo_q[0] : 32'h0;
  end

  // Monitor: compares the line at each rising bit clock edge.
  always @(rise_ev) begin
    logic  eb;
    string et;
    if (exp_b.size() > 0) begin
      eb = exp_b.pop_front();
      et = exp_t.pop_front();
    end else begin
      eb = 1'b0;
      et = "R6";
    end
    check(sdata === eb, et, "sdata", {31'b0, sdata}, {31'b0, eb});
  end

  task automatic bit_cycle(input bit fs_on);
    @(negedge clk);
    bclk  = 1'b0;
    fsync = fs_on ^ cfg_fs_low;
    repeat (4) @(negedge clk);
    -> rise_ev;
    bclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) bit_cycle(1'b0);
  endtask

  // Driver: programs the block, feeds words, queues expected bits, runs the frame.
  task automatic send_frame(input bit dual, input bit dly, input bit fsl,
                            input int l1, input int l2, input int w1, input int w2,
                            input int given, input int extra,
                            input int period, input int fs_width);
    int n1, nslots;
    cfg_dual   = dual;
    cfg_delay  = dly;
    cfg_fs_low = fsl;
    fsync      = fsl;
    cfg_len1   = 7'(l1);
    cfg_len2   = 7'(l2);
    cfg_wcode1 = 3'(w1);
    cfg_wcode2 = 3'(w2);
    n1     = l1 + 1;
    nslots = n1 + (dual ? l2 + 1 : 0);
    if (exp_b.size() > 0) begin
      while (exp_b.size() > 1) begin
        void'(exp_b.pop_back());
        void'(exp_t.pop_back());
      end
    end else begin
      exp_b.push_back(1'b0); exp_t.push_back("R3");
    end
    if (dly) begin
      exp_b.push_back(1'b0); exp_t.push_back("R4");
    end
    for (int s = 0; s < nslots; s++) begin
      logic [31:0] wd;
      int          nb;
      bit          have;
      nb   = (s < n1) ? width_of(w1) : width_of(w2);
      have = (s < given);
      wd   = $urandom;
      if (have) fifo_q.push_back(wd);
      for (int i = nb - 1; i >= 0; i--) begin
        exp_b.push_back(have ? wd[i] : 1'b0);
        exp_t.push_back(!have ? "R7" : (s >= n1 ? "R5" : "R2"));
      end
    end
    for (int e = 0; e < extra; e++) fifo_q.push_back($urandom);
    for (int b = 0; b < period; b++) bit_cycle(b < fs_width);
  endtask

  initial begin
    rst_n = 1'b0; bclk = 1'b1; fsync = 1'b0;
    cfg_fs_low = 1'b0; cfg_delay = 1'b0; cfg_dual = 1'b0;
    cfg_len1 = '0; cfg_len2 = '0; cfg_wcode1 = 3'd2; cfg_wcode2 = 3'd2;
    s_valid = 1'b0; s_data = '0;
    repeat (5) @(negedge clk);
    check(sdata == 1'b0,    "R10", "sdata in reset",    {31'b0, sdata},    0);
    check(underrun == 1'b0, "R10", "underrun in reset", {31'b0, underrun}, 0);
    check(s_ready == 1'b0,  "R10", "s_ready in reset",  {31'b0, s_ready},  0);
    rst_n = 1'b1;
    idle(4);

    // R5 R6 R9: single phase, four 16-bit words, no delay, one spare word left
    send_frame(0, 0, 0, 3, 0, 2, 2, 4, 1, 70, 1);
    check(fifo_q.size() == 1, "R9", "fifo words left", fifo_q.size(), 1);
    @(negedge clk); fifo_q.delete();
    idle(2);

    // R3 R4: stereo I2S, 32-bit, delay 1, active-low sync held half a frame
    send_frame(1, 1, 1, 0, 0, 5, 5, 2, 0, 66, 33);
    send_frame(1, 1, 1, 0, 0, 5, 5, 2, 0, 66, 33);
    check(fifo_q.size() == 0, "R9", "fifo after I2S", fifo_q.size(), 0);

    // R5: left-justified stereo, 16-bit, no delay
    send_frame(1, 0, 0, 0, 0, 2, 2, 2, 0, 36, 17);

    // R4: short-pulse layout with one-bit delay, two 32-bit words
    send_frame(0, 1, 1, 1, 0, 5, 5, 2, 0, 70, 1);

    // R1: other width codes, phases of different widths, code 7 as 32
    send_frame(1, 0, 0, 1, 0, 0, 3, 3, 0, 40, 1);
    send_frame(1, 1, 0, 1, 1, 1, 4, 4, 0, 80, 1);
    send_frame(0, 0, 0, 0, 0, 7, 7, 1, 0, 40, 1);
    check(fifo_q.size() == 0, "R1", "fifo after widths", fifo_q.size(), 0);

    // R8: second frame sync in the middle of a frame restarts it
    send_frame(0, 0, 0, 3, 0, 2, 2, 2, 0, 20, 1);
    send_frame(0, 0, 0, 3, 0, 2, 2, 4, 0, 70, 1);
    check(fifo_q.size() == 0, "R8", "fifo after restart", fifo_q.size(), 0);
    check(underrun == 1'b0,   "R8", "underrun after restart", {31'b0, underrun}, 0);

    // R7: FIFO runs dry, zero slots and sticky flag
    check(underrun == 1'b0, "R7", "underrun before dry run", {31'b0, underrun}, 0);
    send_frame(0, 0, 0, 2, 0, 2, 2, 1, 0, 60, 1);
    check(underrun == 1'b1, "R7", "underrun after dry run", {31'b0, underrun}, 1);
    send_frame(0, 0, 0, 0, 0, 2, 2, 1, 0, 24, 1);
    check(underrun == 1'b1, "R7", "underrun stays set", {31'b0, underrun}, 1);

    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(underrun == 1'b0, "R10", "underrun after reset", {31'b0, underrun}, 0);
    check(sdata == 1'b0,    "R10", "sdata after reset",    {31'b0, sdata},    0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule